// File: doc/BRIEF.md
# Software Flow Controller for a Serial Port

This block adds in-band flow control to a serial port. On the receive side it watches how full the receive FIFO is. When the occupancy rises above a programmable high level, it asks the transmitter to send the stop character. When the occupancy later falls below a programmable low level, it asks for the resume character. Each crossing produces exactly one request. Both character codes are programmable.

It also inspects every byte the receiver delivers. A received stop character holds back the local data stream at the next character boundary. A received resume character releases it. Both events raise a one-cycle pulse. A delete option keeps these control bytes out of the receive FIFO. Two force commands override the hold state: force-stop holds the data stream whatever arrives, and force-resume releases any hold.

The block sits between the receiver, the FIFO and the character serializer. The serializer reports `ser_ready` at each character boundary. The block then loads either a pending control character (which always wins) or the next data byte, unless data is held.

Top module: `swfc_ctrl`

States of the level machine (`lvl_state_e`):
- `LV_OPEN`: no stop has been sent. It goes to `LV_SEND_OFF` when enabled and the level exceeds `xoff_level`.
- `LV_SEND_OFF`: it goes to `LV_CLOSED` on grant.
- `LV_CLOSED`: it goes to `LV_SEND_ON` when the level is below `xon_level`.
- `LV_SEND_ON`: it goes to `LV_OPEN` on grant.
- Every state except `LV_OPEN` returns to `LV_OPEN` when the enable is low.

States of the hold machine (`pause_state_e`):
- `PS_RUN`: it goes to `PS_HELD_FORCED` on force-stop, otherwise to `PS_HELD_REMOTE` on a received stop character.
- `PS_HELD_REMOTE`: it goes to `PS_HELD_FORCED` on force-stop. Otherwise it goes to `PS_RUN` on force-resume, on disable, or on a received resume character.
- `PS_HELD_FORCED`: it goes to `PS_RUN` on a force-resume without a force-stop in the same cycle.

## Requirements
- R1: After reset no control character is pending, data is not held, `got_xon` and `got_xoff` are low, and a valid data byte is popped at the first boundary.
- R2: While enabled and in `LV_OPEN`, a level above `xoff_level` leads, one cycle later, to a stop-character request. The request waits for `ser_ready` and then is loaded ahead of any valid data byte (`src_pop` low in that cycle).
- R3: Only one stop character is sent per rise above `xoff_level`. After it, a level below `xon_level` causes exactly one resume character to be sent, one cycle later, at the next boundary.
- R4: While enabled, a received byte equal to `xoff_code` holds data from the next cycle. The byte popped in the same cycle still goes out. A received `xon_code` releases the hold from the next cycle. Control characters are still sent while data is held.
- R5: `got_xon` and `got_xoff` pulse high in the cycle after a matching byte is received, and only then. When both codes are equal, the stop match takes precedence.
- R6: `fifo_push` mirrors `rxb_valid` and `fifo_byte` mirrors `rxb_data` in the same cycle. The exception is a byte matching either code while enabled with `del_ctrl` set, which is not pushed.
- R7: With `en` low, received bytes neither hold data nor pulse the event outputs, and no control characters are requested. Dropping `en` releases a remote hold one cycle later.
- R8: A `frc_xoff` pulse holds data from the next cycle, whatever `en` is and whatever is received. A `frc_xon` pulse releases a forced or a remote hold from the next cycle.
- R9: When data is popped, `ser_load` is high and `ser_byte` equals `src_byte` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Flow control enable |
| del_ctrl | input | 1 | Drop received control characters from the FIFO |
| xon_code | input | CHAR_W | Resume character code |
| xoff_code | input | CHAR_W | Stop character code |
| xon_level | input | CNT_W | Low level: resume is requested below it |
| xoff_level | input | CNT_W | High level: stop is requested above it |
| frc_xon | input | 1 | Force-resume pulse |
| frc_xoff | input | 1 | Force-stop pulse |
| rxb_valid | input | 1 | Received byte valid |
| rxb_data | input | CHAR_W | Received byte |
| fifo_push | output | 1 | Write strobe to the receive FIFO |
| fifo_byte | output | CHAR_W | Byte written to the receive FIFO |
| fifo_level | input | CNT_W | Receive FIFO occupancy |
| src_valid | input | 1 | Transmit data byte available |
| src_byte | input | CHAR_W | Transmit data byte |
| src_pop | output | 1 | Transmit data byte consumed |
| ser_ready | input | 1 | Serializer at a character boundary |
| ser_load | output | 1 | Load a character into the serializer |
| ser_byte | output | CHAR_W | Character loaded |
| got_xon | output | 1 | Resume character received (pulse) |
| got_xoff | output | 1 | Stop character received (pulse) |

## Verification
A wrong level-machine state shows on `ser_byte` at the very next boundary. It appears as a missing control character, a repeated one, or one of the wrong kind, so the ramp sweep compares every cycle against an arithmetic model of the crossings. A wrong hold state shows on `src_pop` one cycle after the event that should have changed it. The bench therefore samples the pop strobe both in the cycle of each receive or force event and in the cycle after it. The filter sweep covers all byte values with deletion on and off.

// File: rtl/swfc_pkg.sv
`timescale 1ns/1ps
package swfc_pkg;
    typedef enum logic [1:0] {
        LV_OPEN, LV_SEND_OFF, LV_CLOSED, LV_SEND_ON
    } lvl_state_e;

    typedef enum logic [1:0] {
        PS_RUN, PS_HELD_REMOTE, PS_HELD_FORCED
    } pause_state_e;

    typedef enum logic [1:0] {
        CR_NONE, CR_XOFF, CR_XON
    } ctrl_req_e;
endpackage

// File: rtl/swfc_level_fsm.sv
`timescale 1ns/1ps
module swfc_level_fsm
    import swfc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] fifo_level,
    input  logic [CNT_W-1:0] xon_level,
    input  logic [CNT_W-1:0] xoff_level,
    input  logic             grant,
    output ctrl_req_e        req
);
    lvl_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LV_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LV_OPEN:     if (en && fifo_level > xoff_level) state_nx = LV_SEND_OFF;
            LV_SEND_OFF: if (!en) state_nx = LV_OPEN;
                         else if (grant) state_nx = LV_CLOSED;
            LV_CLOSED:   if (!en) state_nx = LV_OPEN;
                         else if (fifo_level < xon_level) state_nx = LV_SEND_ON;
            LV_SEND_ON:  if (!en || grant) state_nx = LV_OPEN;
        endcase
    end

    always_comb begin
        req = CR_NONE;
        if (en) begin
            unique case (state)
                LV_SEND_OFF: req = CR_XOFF;
                LV_SEND_ON:  req = CR_XON;
                default:     req = CR_NONE;
            endcase
        end
    end

    // R3: a granted request is never repeated in the following cycle
    a_r3_drop_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (req == CR_NONE));
    // R7: disabling returns the machine to the open state
    a_r7_open_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == LV_OPEN));
endmodule

// File: rtl/swfc_pause_fsm.sv
`timescale 1ns/1ps
module swfc_pause_fsm
    import swfc_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              del_ctrl,
    input  logic [CHAR_W-1:0] xon_code,
    input  logic [CHAR_W-1:0] xoff_code,
    input  logic              frc_xon,
    input  logic              frc_xoff,
    input  logic              rxb_valid,
    input  logic [CHAR_W-1:0] rxb_data,
    output logic              fifo_push,
    output logic [CHAR_W-1:0] fifo_byte,
    output logic              got_xon,
    output logic              got_xoff,
    output logic              held
);
    pause_state_e state, state_nx;
    logic hit_off, hit_on;

    assign hit_off = rxb_valid && en && (rxb_data == xoff_code);
    assign hit_on  = rxb_valid && en && (rxb_data == xon_code) && !hit_off;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PS_RUN;
            got_xon  <= 1'b0;
            got_xoff <= 1'b0;
        end else begin
            state    <= state_nx;
            got_xon  <= hit_on;
            got_xoff <= hit_off;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_RUN:         if (frc_xoff) state_nx = PS_HELD_FORCED;
                            else if (hit_off) state_nx = PS_HELD_REMOTE;
            PS_HELD_REMOTE: if (frc_xoff) state_nx = PS_HELD_FORCED;
                            else if (frc_xon || !en || hit_on) state_nx = PS_RUN;
            PS_HELD_FORCED: if (frc_xon && !frc_xoff) state_nx = PS_RUN;
            default:        state_nx = PS_RUN;
        endcase
    end

    always_comb begin
        held      = (state != PS_RUN);
        fifo_push = rxb_valid && !(del_ctrl && (hit_on || hit_off));
        fifo_byte = rxb_data;
    end

    // R5: the two received-event pulses never coincide
    a_r5_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(got_xon && got_xoff));
    // R8: a force-stop always results in a hold
    a_r8_force_holds: assert property (@(posedge clk) disable iff (!rst_n)
        frc_xoff |=> held);
    // R4: a received stop character holds data unless force-resume is applied
    a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_off && !frc_xon) |=> held);
endmodule

// File: rtl/swfc_tx_arb.sv
`timescale 1ns/1ps
module swfc_tx_arb
    import swfc_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              ser_ready,
    input  ctrl_req_e         req,
    input  logic [CHAR_W-1:0] xon_code,
    input  logic [CHAR_W-1:0] xoff_code,
    input  logic              held,
    input  logic              src_valid,
    input  logic [CHAR_W-1:0] src_byte,
    output logic              grant,
    output logic              src_pop,
    output logic              ser_load,
    output logic [CHAR_W-1:0] ser_byte
);
    always_comb begin
        grant    = ser_ready && (req != CR_NONE);
        src_pop  = ser_ready && (req == CR_NONE) && src_valid && !held;
        ser_load = grant || src_pop;
        unique case (req)
            CR_XOFF: ser_byte = xoff_code;
            CR_XON:  ser_byte = xon_code;
            default: ser_byte = src_byte;
        endcase
    end
endmodule

// File: rtl/swfc_ctrl.sv
`timescale 1ns/1ps
module swfc_ctrl
    import swfc_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              del_ctrl,
    input  logic [CHAR_W-1:0] xon_code,
    input  logic [CHAR_W-1:0] xoff_code,
    input  logic [CNT_W-1:0]  xon_level,
    input  logic [CNT_W-1:0]  xoff_level,
    input  logic              frc_xon,
    input  logic              frc_xoff,
    input  logic              rxb_valid,
    input  logic [CHAR_W-1:0] rxb_data,
    output logic              fifo_push,
    output logic [CHAR_W-1:0] fifo_byte,
    input  logic [CNT_W-1:0]  fifo_level,
    input  logic              src_valid,
    input  logic [CHAR_W-1:0] src_byte,
    output logic              src_pop,
    input  logic              ser_ready,
    output logic              ser_load,
    output logic [CHAR_W-1:0] ser_byte,
    output logic              got_xon,
    output logic              got_xoff
);
    ctrl_req_e req;
    logic      grant;
    logic      held;

    swfc_level_fsm #(.CNT_W(CNT_W)) u_level (
        .clk(clk), .rst_n(rst_n), .en(en), .fifo_level(fifo_level),
        .xon_level(xon_level), .xoff_level(xoff_level),
        .grant(grant), .req(req)
    );

    swfc_pause_fsm #(.CHAR_W(CHAR_W)) u_pause (
        .clk(clk), .rst_n(rst_n), .en(en), .del_ctrl(del_ctrl),
        .xon_code(xon_code), .xoff_code(xoff_code),
        .frc_xon(frc_xon), .frc_xoff(frc_xoff),
        .rxb_valid(rxb_valid), .rxb_data(rxb_data),
        .fifo_push(fifo_push), .fifo_byte(fifo_byte),
        .got_xon(got_xon), .got_xoff(got_xoff), .held(held)
    );

    swfc_tx_arb #(.CHAR_W(CHAR_W)) u_arb (
        .ser_ready(ser_ready), .req(req),
        .xon_code(xon_code), .xoff_code(xoff_code),
        .held(held), .src_valid(src_valid), .src_byte(src_byte),
        .grant(grant), .src_pop(src_pop),
        .ser_load(ser_load), .ser_byte(ser_byte)
    );

    // R2: a pending control character always wins over data
    a_r2_ctrl_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req != CR_NONE) |-> !src_pop);
    // R4: held data is never popped
    a_r4_held_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !src_pop);
    // R9: a popped byte is loaded unchanged
    a_r9_pop_loads: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> (ser_load && ser_byte == src_byte));
endmodule

// File: tb/swfc_ctrl_test.sv
`timescale 1ns/1ps
module swfc_ctrl_test;
    localparam int CHAR_W = 8;
    localparam int CNT_W  = 8;
    localparam logic [7:0] XON  = 8'h11;
    localparam logic [7:0] XOFF = 8'h13;
    localparam logic [7:0] DAT  = 8'h55;
    localparam int HI = 12;
    localparam int LO = 4;

    logic clk = 1'b0;
    logic rst_n, en, del_ctrl, frc_xon, frc_xoff, rxb_valid, src_valid, ser_ready;
    logic [7:0] xon_code, xoff_code, rxb_data, src_byte;
    logic [CNT_W-1:0] xon_level, xoff_level, fifo_level;
    logic fifo_push, src_pop, ser_load, got_xon, got_xoff;
    logic [7:0] fifo_byte, ser_byte;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    swfc_ctrl #(.CHAR_W(CHAR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .del_ctrl(del_ctrl),
        .xon_code(xon_code), .xoff_code(xoff_code),
        .xon_level(xon_level), .xoff_level(xoff_level),
        .frc_xon(frc_xon), .frc_xoff(frc_xoff),
        .rxb_valid(rxb_valid), .rxb_data(rxb_data),
        .fifo_push(fifo_push), .fifo_byte(fifo_byte), .fifo_level(fifo_level),
        .src_valid(src_valid), .src_byte(src_byte), .src_pop(src_pop),
        .ser_ready(ser_ready), .ser_load(ser_load), .ser_byte(ser_byte),
        .got_xon(got_xon), .got_xoff(got_xoff)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int ms;
        int n_off;
        int n_on;
        int lvl;
        logic [7:0] exp_b;
        logic exp_ctrl;
        rst_n = 0; en = 1; del_ctrl = 1; frc_xon = 0; frc_xoff = 0;
        rxb_valid = 0; rxb_data = 0; src_valid = 0; src_byte = DAT;
        ser_ready = 1; xon_code = XON; xoff_code = XOFF;
        xon_level = LO; xoff_level = HI; fifo_level = 0;
        repeat (3) next_cycle();
        rst_n = 1;
        #1;
        check("R1 no load at reset", ser_load, 0);
        check("R1 got_xon low", got_xon, 0);
        check("R1 got_xoff low", got_xoff, 0);
        next_cycle(); src_valid = 1; #1;
        check("R1 data not held", src_pop, 1);
        check("R9 byte passes", ser_byte, DAT);

        // R2/R3 level ramp with arithmetic crossing model
        ms = 0; n_off = 0; n_on = 0;
        for (int i = 0; i <= 44; i++) begin
            lvl = (i <= 20) ? i : (i <= 23) ? 20 : 44 - i;
            next_cycle(); fifo_level = lvl[CNT_W-1:0]; #1;
            exp_ctrl = (ms == 1) || (ms == 3);
            exp_b = (ms == 1) ? XOFF : (ms == 3) ? XON : DAT;
            check("R2 ramp load", ser_load, 1);
            check("R2 ramp byte", ser_byte, exp_b);
            check("R2 ramp ctrl before data", src_pop, !exp_ctrl);
            if (ser_load && ser_byte == XOFF) n_off++;
            if (ser_load && ser_byte == XON) n_on++;
            if (ms == 0 && lvl > HI) ms = 1;
            else if (ms == 1) ms = 2;
            else if (ms == 2 && lvl < LO) ms = 3;
            else if (ms == 3) ms = 0;
        end
        check("R3 one stop per crossing", n_off, 1);
        check("R3 one resume per crossing", n_on, 1);

        // R2 request waits for a boundary
        next_cycle(); ser_ready = 0; fifo_level = 15; #1;
        check("R2 no load without boundary", ser_load, 0);
        next_cycle(); #1;
        check("R2 request waits", ser_load, 0);
        check("R2 no pop while waiting", src_pop, 0);
        next_cycle(); ser_ready = 1; #1;
        check("R2 stop sent at boundary", ser_byte, XOFF);
        check("R2 stop loaded", ser_load, 1);
        check("R2 data deferred", src_pop, 0);
        next_cycle(); #1;
        check("R3 no repeat while high", ser_byte, DAT);
        next_cycle(); fifo_level = 0; #1;
        check("R3 closed cycle carries data", ser_byte, DAT);
        next_cycle(); #1;
        check("R3 resume sent", ser_byte, XON);
        next_cycle(); #1;
        check("R3 back to data", src_pop, 1);

        // R5/R6 exhaustive receive filter sweep
        for (int d = 0; d < 2; d++) begin
            for (int b = 0; b < 256; b++) begin
                next_cycle(); del_ctrl = d[0]; rxb_valid = 1; rxb_data = b[7:0]; #1;
                check("R6 push", fifo_push, !(d == 1 && (b == XON || b == XOFF)));
                check("R6 byte", fifo_byte, b);
                @(posedge clk); #1;
                check("R5 got_xon", got_xon, b == XON);
                check("R5 got_xoff", got_xoff, b == XOFF);
            end
        end
        next_cycle(); rxb_valid = 0; #1;
        check("R4 held after stop received", src_pop, 0);
        check("R4 nothing loaded while held", ser_load, 0);
        fifo_level = 15;
        next_cycle(); #1;
        check("R4 control sent while held", ser_byte, XOFF);
        check("R4 control loaded while held", ser_load, 1);
        next_cycle(); fifo_level = 0; #1;
        check("R4 held, closed", ser_load, 0);
        next_cycle(); #1;
        check("R4 resume sent while held", ser_byte, XON);
        next_cycle(); rxb_valid = 1; rxb_data = XON; #1;
        check("R4 still held in receive cycle", src_pop, 0);
        next_cycle(); rxb_valid = 0; #1;
        check("R4 released after resume", src_pop, 1);
        next_cycle(); rxb_valid = 1; rxb_data = XOFF; #1;
        check("R4 current byte still goes", src_pop, 1);
        next_cycle(); rxb_valid = 0; #1;
        check("R4 held after stop", src_pop, 0);

        // R7 disable
        next_cycle(); en = 0; #1;
        check("R7 hold persists this cycle", src_pop, 0);
        next_cycle(); #1;
        check("R7 disable releases hold", src_pop, 1);
        next_cycle(); rxb_valid = 1; rxb_data = XOFF; #1;
        check("R7 stop byte pushed when off", fifo_push, 1);
        next_cycle(); rxb_valid = 0; #1;
        check("R7 no hold when off", src_pop, 1);
        check("R7 no pulse when off", got_xoff, 0);
        fifo_level = 15;
        for (int k = 0; k < 3; k++) begin
            next_cycle(); #1;
            check("R7 no control when off", ser_byte, DAT);
        end
        next_cycle(); en = 1; #1;
        check("R7 enable cycle carries data", ser_byte, DAT);
        next_cycle(); #1;
        check("R2 stop after enable", ser_byte, XOFF);
        next_cycle(); fifo_level = 0; #1;
        check("R3 closed carries data", ser_byte, DAT);
        next_cycle(); #1;
        check("R3 resume after enable", ser_byte, XON);

        // R8 force commands
        next_cycle(); frc_xoff = 1; #1;
        check("R8 force acts next cycle", src_pop, 1);
        next_cycle(); frc_xoff = 0; #1;
        check("R8 forced hold", src_pop, 0);
        next_cycle(); rxb_valid = 1; rxb_data = XON; #1;
        check("R8 forced, resume byte cycle", src_pop, 0);
        next_cycle(); rxb_valid = 0; #1;
        check("R8 resume byte ignored when forced", src_pop, 0);
        check("R5 pulse still reported", got_xon, 1);
        next_cycle(); frc_xon = 1; #1;
        check("R8 force-resume cycle", src_pop, 0);
        next_cycle(); frc_xon = 0; #1;
        check("R8 force-resume releases", src_pop, 1);
        next_cycle(); rxb_valid = 1; rxb_data = XOFF; #1;
        next_cycle(); rxb_valid = 0; #1;
        check("R8 remote hold set", src_pop, 0);
        next_cycle(); frc_xon = 1; #1;
        next_cycle(); frc_xon = 0; #1;
        check("R8 force-resume clears remote hold", src_pop, 1);
        next_cycle(); en = 0; frc_xoff = 1; #1;
        next_cycle(); frc_xoff = 0; #1;
        check("R8 force holds when off", src_pop, 0);
        next_cycle(); frc_xon = 1; #1;
        next_cycle(); frc_xon = 0; #1;
        check("R8 force-resume when off", src_pop, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule